// File: doc/BRIEF.md
# Boot-Time Debug Lock Sequencer

This block runs once after each power-on. It issues a single read of a 32-bit protection word from a fixed address in non-volatile memory over a request/valid port. It then classifies the word against three protection codes and writes a lock value into a debug-control register.

A word that matches the level-1 or level-3 code is converted into the level-2 code before it is stored. Any other word, including the level-2 code itself, is stored unchanged. Debug access is therefore closed exactly when the stored value equals the level-2 code, and open otherwise.

The block also presents a two-bit protection level for a later command-filtering stage. It raises a completion flag that stays high until the next power-on. A warm reset is not an input of this block, so only a power-on starts the sequence again.

Top module: `boot_dbg_lock`

## Requirements
- R1: After power-on reset is released, the block raises `mem_req` for exactly one cycle while `mem_addr` carries byte address 0x0000_02FC, and makes no other request before the next power-on.
- R2: A word equal to the level-1 code 0x1234_5678 stores 0x8765_4321 in `lock_reg` and sets `prot_level` to 1.
- R3: A word equal to the level-3 code 0x4321_8765 stores 0x8765_4321 in `lock_reg` and sets `prot_level` to 3.
- R4: A word equal to the level-2 code 0x8765_4321 stores that word in `lock_reg` and sets `prot_level` to 2.
- R5: Any other word is stored unchanged in `lock_reg`, and `prot_level` is 0.
- R6: Once `boot_done` is high, `dbg_en` is 1 exactly when `lock_reg` differs from 0x8765_4321.
- R7: `dbg_en` is 0 from power-on until the lock value has been written.
- R8: `boot_done` rises in the cycle in which `lock_reg` and `dbg_en` take their final values, and it then stays high with all outputs stable until the next power-on.
- R9: `prot_level` takes its value one cycle after the word is accepted. `lock_reg`, `dbg_en` and `boot_done` change one cycle after that.
- R10: `mem_valid` is ignored unless the block is waiting for its read data. A late or spurious valid, whatever data it carries, leaves every output unchanged.
- R11: While `por_n` is low, `mem_req`, `dbg_en`, `boot_done`, `prot_level` and `lock_reg` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| mem_req | output | 1 | Read request pulse to non-volatile memory |
| mem_addr | output | ADDR_W | Byte address of the protection word |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| lock_reg | output | 32 | Debug-control register contents |
| dbg_en | output | 1 | Debug access enable |
| prot_level | output | 2 | Protection level: 0 none, 1, 2, 3 |
| boot_done | output | 1 | Sequence complete, held until power-on |

## Verification
Call the clock edge at which `mem_valid` is sampled high while waiting edge A. `prot_level` changes at edge A+1, and `lock_reg`, `dbg_en` and `boot_done` all change together at edge A+2. The bench drives `mem_valid` a chosen number of cycles after it observes the request. It samples on falling edges only: after A it checks that nothing has moved yet, after A+1 it checks the level alone, and after A+2 it checks the register, the enable and the done flag. It then keeps watching to confirm that no further request appears and that a late valid carrying new data leaves every output untouched.

// File: rtl/boot_lock_pkg.sv
package boot_lock_pkg;

  localparam logic [31:0] CODE_L1 = 32'h1234_5678;
  localparam logic [31:0] CODE_L2 = 32'h8765_4321;
  localparam logic [31:0] CODE_L3 = 32'h4321_8765;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT_DATA,
    ST_COMPARE,
    ST_WRITE_LOCK,
    ST_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_ONE  = 2'd1,
    LVL_TWO  = 2'd2,
    LVL_THREE = 2'd3
  } prot_lvl_t;

  // Level classification of a fetched protection word.
  function automatic prot_lvl_t classify(input logic [31:0] w);
    if (w == CODE_L1)      return LVL_ONE;
    else if (w == CODE_L2) return LVL_TWO;
    else if (w == CODE_L3) return LVL_THREE;
    else                   return LVL_NONE;
  endfunction

  // Value written into the debug-control register for a given word.
  function automatic logic [31:0] lock_value(input logic [31:0] w);
    if (w == CODE_L1 || w == CODE_L3) return CODE_L2;
    else                              return w;
  endfunction

  // Debug access is open unless the stored value is the level-2 code.
  function automatic logic debug_open(input logic [31:0] stored);
    return stored != CODE_L2;
  endfunction

endpackage

// File: rtl/bl_fetch.sv
module bl_fetch #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              waiting,
  input  logic              mem_valid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              word_ok,
  output logic [WORD_W-1:0] word_q
);

  assign mem_req = issue;
  assign word_ok = waiting & mem_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_ok) word_q <= mem_rdata;
  end

  // R1: the request is a single-cycle pulse
  a_r1_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R10: captured word changes only on an accepted beat
  a_r10_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !word_ok |=> $stable(word_q));

endmodule

// File: rtl/bl_decide.sv
module bl_decide
  import boot_lock_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval,
  input  logic [WORD_W-1:0] word,
  output prot_lvl_t         level_q,
  output logic [WORD_W-1:0] lock_val_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q    <= LVL_NONE;
      lock_val_q <= '0;
    end else if (eval) begin
      level_q    <= classify(word);
      lock_val_q <= lock_value(word);
    end
  end

  // R2/R3: a level-1 or level-3 word never yields its own code as lock value
  a_r3_convert: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q == LVL_ONE || level_q == LVL_THREE) |-> lock_val_q == CODE_L2);

  // R9: level changes only on the evaluation cycle
  a_r9_level_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !eval |=> $stable(level_q));

endmodule

// File: rtl/bl_lockreg.sv
module bl_lockreg
  import boot_lock_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] lock_q,
  output logic              dbg_en_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q   <= '0;
      dbg_en_q <= 1'b0;
    end else if (wr) begin
      lock_q   <= wdata;
      dbg_en_q <= debug_open(wdata);
    end
  end

  // R8: register is written only by the write strobe
  a_r8_lock_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(lock_q) && $stable(dbg_en_q));

endmodule

// File: rtl/boot_dbg_lock.sv
module boot_dbg_lock
  import boot_lock_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] PROT_ADDR = 32'h0000_02FC
) (
  input  logic              clk,
  input  logic              por_n,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [31:0]       mem_rdata,
  output logic [31:0]       lock_reg,
  output logic              dbg_en,
  output logic [1:0]        prot_level,
  output logic              boot_done
);

  localparam int WORD_W = 32;

  seq_state_t state_q, state_d;

  // Named internal events
  logic ev_issue, ev_wait, ev_word_ok, ev_eval, ev_write;
  logic [WORD_W-1:0] fetched_word, lock_val;
  prot_lvl_t level;

  assign ev_issue = (state_q == ST_REQ);
  assign ev_wait  = (state_q == ST_WAIT_DATA);
  assign ev_eval  = (state_q == ST_COMPARE);
  assign ev_write = (state_q == ST_WRITE_LOCK);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       state_d = ST_REQ;
      ST_REQ:        state_d = ST_WAIT_DATA;
      ST_WAIT_DATA:  if (ev_word_ok) state_d = ST_COMPARE;
      ST_COMPARE:    state_d = ST_WRITE_LOCK;
      ST_WRITE_LOCK: state_d = ST_DONE;
      ST_DONE:       state_d = ST_DONE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  bl_fetch #(.WORD_W(WORD_W)) u_fetch (
    .clk       (clk),
    .rst_n     (por_n),
    .issue     (ev_issue),
    .waiting   (ev_wait),
    .mem_valid (mem_valid),
    .mem_rdata (mem_rdata),
    .mem_req   (mem_req),
    .word_ok   (ev_word_ok),
    .word_q    (fetched_word)
  );

  bl_decide #(.WORD_W(WORD_W)) u_decide (
    .clk        (clk),
    .rst_n      (por_n),
    .eval       (ev_eval),
    .word       (fetched_word),
    .level_q    (level),
    .lock_val_q (lock_val)
  );

  bl_lockreg #(.WORD_W(WORD_W)) u_lockreg (
    .clk      (clk),
    .rst_n    (por_n),
    .wr       (ev_write),
    .wdata    (lock_val),
    .lock_q   (lock_reg),
    .dbg_en_q (dbg_en)
  );

  assign mem_addr   = PROT_ADDR[ADDR_W-1:0];
  assign prot_level = level;
  assign boot_done  = (state_q == ST_DONE);

  // R7: debug stays closed until the sequence has finished
  a_r7_closed_early: assert property (@(posedge clk) disable iff (!por_n)
    !boot_done |-> !dbg_en);

  // R6: enable agrees with the stored register
  a_r6_enable_match: assert property (@(posedge clk) disable iff (!por_n)
    boot_done |-> dbg_en == (lock_reg != CODE_L2));

  // R8: completion flag holds and no further request is made
  a_r8_done_hold: assert property (@(posedge clk) disable iff (!por_n)
    boot_done |=> boot_done);
  a_r8_no_req_after: assert property (@(posedge clk) disable iff (!por_n)
    boot_done |-> !mem_req);

  // R9: the register is written the cycle after the level is latched
  a_r9_order: assert property (@(posedge clk) disable iff (!por_n)
    ev_eval |=> ev_write);

  // R1: requests carry the protection word address
  a_r1_addr: assert property (@(posedge clk) disable iff (!por_n)
    mem_req |-> mem_addr == PROT_ADDR[ADDR_W-1:0]);

endmodule

// File: tb/tb_boot_dbg_lock.sv
module tb_boot_dbg_lock;

  localparam logic [31:0] K1 = 32'h1234_5678;
  localparam logic [31:0] K2 = 32'h8765_4321;
  localparam logic [31:0] K3 = 32'h4321_8765;
  localparam int NV = 8;
  localparam logic [31:0] VW [NV] = '{K1, K3, K2, 32'h0000_0000,
                                      32'hFFFF_FFFF, 32'h8765_4320,
                                      32'h1234_5679, K1};
  localparam int VL [NV] = '{1, 3, 2, 1, 5, 1, 2, 7};

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic mem_valid = 1'b0;
  logic [31:0] mem_rdata = 32'h0;
  logic mem_req, dbg_en, boot_done;
  logic [31:0] mem_addr, lock_reg;
  logic [1:0] prot_level;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  boot_dbg_lock dut (
    .clk(clk), .por_n(por_n), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata), .lock_reg(lock_reg),
    .dbg_en(dbg_en), .prot_level(prot_level), .boot_done(boot_done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_reset();
    chk(mem_req == 0, "R11 mem_req", 32'(mem_req), 0);
    chk(dbg_en == 0, "R11 dbg_en", 32'(dbg_en), 0);
    chk(boot_done == 0, "R11 boot_done", 32'(boot_done), 0);
    chk(prot_level == 0, "R11 prot_level", 32'(prot_level), 0);
    chk(lock_reg == 0, "R11 lock_reg", lock_reg, 0);
  endtask

  task automatic run_vec(input logic [31:0] w, input int lat);
    bit got = 0;
    int lvl_e;
    logic [31:0] reg_e;
    string tag;
    if (w == K1) begin lvl_e = 1; reg_e = K2; tag = "R2"; end
    else if (w == K3) begin lvl_e = 3; reg_e = K2; tag = "R3"; end
    else if (w == K2) begin lvl_e = 2; reg_e = K2; tag = "R4"; end
    else begin lvl_e = 0; reg_e = w; tag = "R5"; end

    por_n = 1'b0; mem_valid = 1'b0; mem_rdata = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    check_reset();
    por_n = 1'b1;
    for (int i = 0; i < 20 && !got; i++) begin
      @(negedge clk);
      chk(dbg_en == 0, "R7 open before request", 32'(dbg_en), 0);
      if (mem_req) begin
        got = 1;
        chk(mem_addr == 32'h0000_02FC, "R1 address", mem_addr, 32'h2FC);
      end
    end
    chk(got, "R1 request seen", 32'(got), 1);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk(mem_req == 0, "R1 single pulse", 32'(mem_req), 0);
    end
    mem_valid = 1'b1; mem_rdata = w;
    @(negedge clk);                     // edge A passed
    mem_valid = 1'b0; mem_rdata = 32'hDEAD_BEEF;
    chk(boot_done == 0, "R9 done early", 32'(boot_done), 0);
    chk(prot_level == 0, "R9 level early", 32'(prot_level), 0);
    @(negedge clk);                     // edge A+1
    chk(prot_level == lvl_e[1:0], {tag, " prot_level"}, 32'(prot_level), lvl_e);
    chk(boot_done == 0, "R9 done at A+1", 32'(boot_done), 0);
    chk(dbg_en == 0, "R7 open at A+1", 32'(dbg_en), 0);
    @(negedge clk);                     // edge A+2
    chk(lock_reg == reg_e, {tag, " lock_reg"}, lock_reg, reg_e);
    chk(dbg_en == (reg_e != K2), "R6 dbg_en", 32'(dbg_en), 32'(reg_e != K2));
    chk(boot_done == 1, "R8 done at A+2", 32'(boot_done), 1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(!mem_req && boot_done, "R8 hold / no request", {mem_req, boot_done}, 1);
    end
    // spurious valid with other data must be ignored
    mem_valid = 1'b1; mem_rdata = ~w;
    @(negedge clk);
    mem_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(lock_reg == reg_e, "R10 lock_reg unchanged", lock_reg, reg_e);
    chk(prot_level == lvl_e[1:0], "R10 level unchanged", 32'(prot_level), lvl_e);
    chk(dbg_en == (reg_e != K2), "R10 dbg_en unchanged", 32'(dbg_en), 32'(reg_e != K2));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check_reset();
    for (int v = 0; v < NV; v++) run_vec(VW[v], VL[v]);

    // power-on in the middle of a fetch restarts cleanly (R11, R1)
    por_n = 1'b0; repeat (2) @(negedge clk);
    por_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(boot_done == 0, "R7 waiting without data", 32'(boot_done), 0);
    chk(dbg_en == 0, "R7 closed while waiting", 32'(dbg_en), 0);
    por_n = 1'b0;
    @(negedge clk);
    check_reset();
    run_vec(K3, 2);

    // valid during the request cycle only, then the real data (R10)
    por_n = 1'b0; repeat (2) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    chk(mem_req == 1, "R1 request after release", 32'(mem_req), 1);
    mem_valid = 1'b1; mem_rdata = K2;   // sampled while still requesting
    @(negedge clk);
    mem_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(boot_done == 0, "R10 early valid ignored", 32'(boot_done), 0);
    chk(prot_level == 0, "R10 early valid level", 32'(prot_level), 0);
    mem_valid = 1'b1; mem_rdata = 32'h0BAD_F00D;
    @(negedge clk);
    mem_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(lock_reg == 32'h0BAD_F00D, "R5 raw after early valid", lock_reg, 32'h0BAD_F00D);
    chk(dbg_en == 1, "R6 open for raw word", 32'(dbg_en), 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule